// File: doc/BRIEF.md
# NAND device cycle sequencer

This block turns single bus-cycle requests from an internal port into the pin waveforms of a NAND flash device: chip enable, command latch enable, address latch enable, the write and read strobes, and a 16-bit data bus. The bus is split into output, output-enable and input for the pad ring. Each request asks for one command byte, one address byte, or one data transfer. A data transfer is a write or a read, and it is 8 or 16 bits wide. On a read, the sampled bus value comes back on a response port.

All timing comes from clock counts held on configuration inputs: the chip-enable setup, the strobe low and high widths, the read access delay, and four spacing rules between strobes (read to write, read to read, write to read, address to data). The requester issues one request at a time. It waits for `busy` to fall before it issues the next one.

Top module: `nand_cycle_seq`

## Requirements
- R1: A request is accepted when `reqValid` is high and `busy` is low. Type 0 is a command cycle and type 1 is an address cycle; both use the write strobe, with `nandCle` (type 0) or `nandAle` (type 1) held high through the cycle. Type 2 is a data cycle with neither latch enable high; it uses the write strobe when `reqWrite`=1 and the read strobe otherwise. The two strobes are never low together.
- R2: The active strobe stays low for exactly the low count of clocks. After it rises, `nandCeN` returns high exactly the high count of clocks later, which ends the cycle.
- R3: `nandCeN` falls on the clock after acceptance. The strobe falls exactly setup-count clocks after that, unless a spacing rule (R5 to R7) holds it back. In that case it falls on the first clock where the rule is met.
- R4: On a read, the bus is captured on the access-count-th clock edge after the read strobe falls. `rspValid` pulses for one clock on the next cycle, carrying the captured value. The cycle is never ended before the capture.
- R5: A write strobe that follows a read strobe falls no sooner than the read-to-write count after the read strobe rose. A read after a read waits for the read-to-read count.
- R6: A read strobe that follows a command or data write strobe falls no sooner than the write-to-read count after that strobe rose.
- R7: A data strobe that follows an address strobe waits for the address-to-data count. When the data cycle is a read, it waits for the larger of that count and the write-to-read count.
- R8: A 16-bit data write drives bits 7:0 of `reqData` on `nandDqOut[7:0]` and bits 23:16 on `nandDqOut[15:8]`. An 8-bit data write drives `nandDqOut[15:8]` as zero.
- R9: A 16-bit read returns `nandDqIn[7:0]` in `rspData[7:0]` and `nandDqIn[15:8]` in `rspData[23:16]`, with all other bits zero. An 8-bit read returns only `nandDqIn[7:0]`, in bits 7:0.
- R10: Command and address cycles drive `reqData[7:0]` with `nandDqOut[15:8]` zero, even when `reqWide` is 1.
- R11: Every timing count of 0 behaves as 1.
- R12: `nandDqOe` is high only during write, command and address cycles. It is low at least one clock before the read strobe falls, and it stays low through the whole read cycle.
- R13: A request of type 3 is ignored: `busy` stays low and `nandCeN` stays high.
- R14: During reset `nandCeN`, `nandWeN` and `nandReN` are high, `nandCle`, `nandAle`, `nandDqOe`, `busy` and `rspValid` are low, and no spacing rule applies to the first cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqType | input | 2 | 0 command, 1 address, 2 data, 3 ignored |
| reqWrite | input | 1 | Data cycle direction, 1 = write |
| reqWide | input | 1 | Data cycle uses the 16-bit bus |
| reqData | input | 32 | Byte(s) to drive, at bits 7:0 and 23:16 |
| busy | output | 1 | A cycle is in progress |
| rspValid | output | 1 | One-clock pulse with read data |
| rspData | output | 32 | Read data, bytes at bits 7:0 and 23:16 |
| cfgSetup | input | CNT_W | Chip-enable setup clocks |
| cfgLow | input | CNT_W | Strobe low clocks |
| cfgHigh | input | CNT_W | Strobe high clocks |
| cfgAccess | input | CNT_W | Read strobe fall to capture clocks |
| cfgRdToWr | input | CNT_W | Read rise to write fall spacing |
| cfgRdToRd | input | CNT_W | Read rise to read fall spacing |
| cfgWrToRd | input | CNT_W | Write rise to read fall spacing |
| cfgAddrToData | input | CNT_W | Address rise to data fall spacing |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDqOut | output | 16 | Data bus output value |
| nandDqOe | output | 1 | Data bus output enable |
| nandDqIn | input | 16 | Data bus input value |

## Verification
The embedded assertions check the invariants that hold on every clock. The two strobes are never low together, and the latch enables never overlap. Chip enable is low for at least a clock before any strobe falls. The bus is released before and during read strobes. The block is quiet while idle. A response only follows a pending capture. The exact clock counts need the bench's scenarios: strobe widths, setup, the four spacing rules and which of them binds, the capture instant, and the byte packing. The bench sweeps several timing configurations, including zero counts, through a fixed request mix. It drives a bus value that changes every clock, so a capture that lands one clock early or late returns a different value.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [1:0] TY_CMD  = 2'd0;
  localparam logic [1:0] TY_ADDR = 2'd1;
  localparam logic [1:0] TY_DATA = 2'd2;
  localparam logic [1:0] TY_NONE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_LOW,
    ST_HIGH
  } seqState_t;

  typedef enum logic [1:0] {
    PK_NONE,
    PK_WRITE,
    PK_ADDR,
    PK_READ
  } strobeKind_t;

  typedef struct packed {
    logic latchReq;
    logic rdStart;
  } ctlStrobes_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqType,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic [CNT_W-1:0] cfgRdToWr,
  input  logic [CNT_W-1:0] cfgRdToRd,
  input  logic [CNT_W-1:0] cfgWrToRd,
  input  logic [CNT_W-1:0] cfgAddrToData,
  input  logic             accPending,
  input  logic             accDone,
  output ctlStrobes_t      ctl,
  output logic             busy,
  output logic             nandCeN,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic             nandDqOe
);

  localparam int GAP_W = CNT_W + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  function automatic logic [CNT_W-1:0] eff(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  seqState_t        state;
  strobeKind_t      prevKind;
  strobeKind_t      curKind;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       typeReg;
  logic             isRead;
  logic [GAP_W-1:0] sinceRise;
  logic [CNT_W-1:0] gapNeed;
  logic             gapOk;
  logic             accept;
  logic             goLow;

  logic [CNT_W-1:0] effS, effL, effH, effRW, effRR, effWR, effAD;
  assign effS  = eff(cfgSetup);
  assign effL  = eff(cfgLow);
  assign effH  = eff(cfgHigh);
  assign effRW = eff(cfgRdToWr);
  assign effRR = eff(cfgRdToRd);
  assign effWR = eff(cfgWrToRd);
  assign effAD = eff(cfgAddrToData);

  assign accept = (state == ST_IDLE) && reqValid && (reqType != TY_NONE);

  always_comb begin
    if (isRead)                curKind = PK_READ;
    else if (typeReg == TY_ADDR) curKind = PK_ADDR;
    else                       curKind = PK_WRITE;
  end

  // Spacing the next strobe owes to the previous one
  always_comb begin
    gapNeed = '0;
    if (isRead) begin
      case (prevKind)
        PK_READ:  gapNeed = effRR;
        PK_WRITE: gapNeed = effWR;
        PK_ADDR:  gapNeed = (effWR > effAD) ? effWR : effAD;
        default:  gapNeed = '0;
      endcase
    end else if (prevKind == PK_READ) begin
      gapNeed = effRW;
    end else if (prevKind == PK_ADDR && typeReg == TY_DATA) begin
      gapNeed = effAD;
    end
  end

  assign gapOk = ({1'b0, sinceRise} + (GAP_W + 1)'(1)) >= (GAP_W + 1)'(gapNeed);
  assign goLow = ((state == ST_SETUP && cnt == '0) || state == ST_WAIT) && gapOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      typeReg   <= TY_CMD;
      isRead    <= 1'b0;
      prevKind  <= PK_NONE;
      sinceRise <= GAP_MAX;
    end else begin
      if (sinceRise != GAP_MAX) sinceRise <= sinceRise + GAP_W'(1);
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_SETUP;
            cnt     <= effS - CNT_W'(1);
            typeReg <= reqType;
            isRead  <= (reqType == TY_DATA) && !reqWrite;
          end
        end
        ST_SETUP: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (gapOk) begin
            state <= ST_LOW;
            cnt   <= effL - CNT_W'(1);
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (gapOk) begin
            state <= ST_LOW;
            cnt   <= effL - CNT_W'(1);
          end
        end
        ST_LOW: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else begin
            state     <= ST_HIGH;
            cnt       <= effH - CNT_W'(1);
            sinceRise <= '0;
            prevKind  <= curKind;
          end
        end
        ST_HIGH: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else if (!accPending || accDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ctl.latchReq = accept;
  assign ctl.rdStart  = goLow && isRead;

  assign busy     = (state != ST_IDLE);
  assign nandCeN  = (state == ST_IDLE);
  assign nandCle  = busy && (typeReg == TY_CMD);
  assign nandAle  = busy && (typeReg == TY_ADDR);
  assign nandWeN  = !((state == ST_LOW) && !isRead);
  assign nandReN  = !((state == ST_LOW) && isRead);
  assign nandDqOe = busy && !isRead;

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  assert_latch_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  assert_ce_setup_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nandWeN) || $fell(nandReN)) |-> $past(!nandCeN));

  assert_quiet_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (nandCeN && nandWeN && nandReN && !nandDqOe));

  assert_bus_off_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDqOe);

  assert_release_early_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandReN) |-> !$past(nandDqOe));

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [1:0]       reqType,
  input  logic             reqWide,
  input  logic [31:0]      reqData,
  input  logic [CNT_W-1:0] cfgAccess,
  input  logic [15:0]      nandDqIn,
  output logic [15:0]      nandDqOut,
  output logic             accPending,
  output logic             accDone,
  output logic             rspValid,
  output logic [31:0]      rspData
);

  logic [1:0]       typeReg;
  logic             wideReg;
  logic [31:0]      dataReg;
  logic [CNT_W-1:0] accCnt;
  logic [CNT_W-1:0] effA;

  assign effA = (cfgAccess == '0) ? CNT_W'(1) : cfgAccess;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeReg <= TY_CMD;
      wideReg <= 1'b0;
      dataReg <= '0;
    end else if (ctl.latchReq) begin
      typeReg <= reqType;
      wideReg <= reqWide;
      dataReg <= reqData;
    end
  end

  // Upper lane carries byte N+1 only on 16-bit data cycles
  assign nandDqOut = {((typeReg == TY_DATA) && wideReg) ? dataReg[23:16] : 8'h00,
                      dataReg[7:0]};

  assign accDone = accPending && (accCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accCnt     <= '0;
      accPending <= 1'b0;
      rspValid   <= 1'b0;
      rspData    <= '0;
    end else begin
      rspValid <= 1'b0;
      if (ctl.rdStart) begin
        accCnt     <= effA - CNT_W'(1);
        accPending <= 1'b1;
      end else if (accPending) begin
        if (accCnt == '0) begin
          accPending <= 1'b0;
          rspValid   <= 1'b1;
          rspData    <= wideReg ? {8'h00, nandDqIn[15:8], 8'h00, nandDqIn[7:0]}
                                : {24'h0, nandDqIn[7:0]};
        end else begin
          accCnt <= accCnt - CNT_W'(1);
        end
      end
    end
  end

  assert_rsp_after_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(accPending));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqType,
  input  logic             reqWrite,
  input  logic             reqWide,
  input  logic [31:0]      reqData,
  output logic             busy,
  output logic             rspValid,
  output logic [31:0]      rspData,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic [CNT_W-1:0] cfgAccess,
  input  logic [CNT_W-1:0] cfgRdToWr,
  input  logic [CNT_W-1:0] cfgRdToRd,
  input  logic [CNT_W-1:0] cfgWrToRd,
  input  logic [CNT_W-1:0] cfgAddrToData,
  output logic             nandCeN,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [15:0]      nandDqOut,
  output logic             nandDqOe,
  input  logic [15:0]      nandDqIn
);

  ctlStrobes_t ctl;
  logic        accPending;
  logic        accDone;

  nand_seq_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqWrite(reqWrite), .cfgSetup(cfgSetup), .cfgLow(cfgLow), .cfgHigh(cfgHigh),
    .cfgRdToWr(cfgRdToWr), .cfgRdToRd(cfgRdToRd), .cfgWrToRd(cfgWrToRd),
    .cfgAddrToData(cfgAddrToData), .accPending(accPending), .accDone(accDone),
    .ctl(ctl), .busy(busy), .nandCeN(nandCeN), .nandCle(nandCle),
    .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN), .nandDqOe(nandDqOe)
  );

  nand_seq_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqType(reqType), .reqWide(reqWide),
    .reqData(reqData), .cfgAccess(cfgAccess), .nandDqIn(nandDqIn),
    .nandDqOut(nandDqOut), .accPending(accPending), .accDone(accDone),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: tb/sim_nand_cycle_seq.sv
module sim_nand_cycle_seq;

  localparam int CNT_W = 6;
  localparam int WD_LIMIT = 150000;
  localparam int K_NONE = 0, K_CMD = 1, K_ADDR = 2, K_DWR = 3, K_RD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqType = 2'd0;
  logic reqWrite = 1'b0;
  logic reqWide = 1'b0;
  logic [31:0] reqData = '0;
  logic busy, rspValid;
  logic [31:0] rspData;
  logic [CNT_W-1:0] cS = '0, cL = '0, cH = '0, cA = '0;
  logic [CNT_W-1:0] cRW = '0, cRR = '0, cWR = '0, cAD = '0;
  logic nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic [15:0] nandDqOut;
  logic [15:0] nandDqIn = '0;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  int lastRise = -1000;
  int prevKind = K_NONE;

  always #5 clk = ~clk;

  nand_cycle_seq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqData(reqData), .busy(busy),
    .rspValid(rspValid), .rspData(rspData), .cfgSetup(cS), .cfgLow(cL),
    .cfgHigh(cH), .cfgAccess(cA), .cfgRdToWr(cRW), .cfgRdToRd(cRR),
    .cfgWrToRd(cWR), .cfgAddrToData(cAD), .nandCeN(nandCeN), .nandCle(nandCle),
    .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDqOut(nandDqOut), .nandDqOe(nandDqOe), .nandDqIn(nandDqIn)
  );

  function automatic logic [15:0] busVal(input int t);
    logic [7:0] b;
    b = t[7:0];
    return {b + 8'h51, b};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) nandDqIn = busVal(cyc);

  function automatic int eff(input logic [CNT_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int needGap(input int pk, input int ck);
    if (ck == K_RD) begin
      if (pk == K_RD) return eff(cRR);
      if (pk == K_CMD || pk == K_DWR) return eff(cWR);
      if (pk == K_ADDR) return (eff(cWR) > eff(cAD)) ? eff(cWR) : eff(cAD);
      return 0;
    end
    if (pk == K_RD) return eff(cRW);
    if (pk == K_ADDR && ck == K_DWR) return eff(cAD);
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
      finishRun();
    end
  end

  // Issue one cycle and check its waveform against the timing rules
  task automatic runCycle(input int ty, input bit wr, input bit wd, input logic [31:0] d);
    int kind, g, tc, tf, tr, tce, trsp, expTf, expRsp;
    bit isRd, oeSeen, cleAt, aleAt, oeAt, otherLow;
    logic [15:0] dqAt, expDq;
    logic [31:0] rsp, expData;
    logic [15:0] bv;
    isRd = (ty == 2) && !wr;
    kind = (ty == 0) ? K_CMD : (ty == 1) ? K_ADDR : (wr ? K_DWR : K_RD);
    g = needGap(prevKind, kind);
    @(negedge clk);
    reqValid = 1'b1; reqType = 2'(ty); reqWrite = wr; reqWide = wd; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    tc = cyc;
    chk(!nandCeN, "R3 chip enable falls after accept", 32'(nandCeN), 0);
    tf = -1; tr = -1; tce = -1; trsp = -1; oeSeen = 0; rsp = '0;
    cleAt = 0; aleAt = 0; oeAt = 0; dqAt = '0; otherLow = 0;
    for (int k = 0; k < 600 && tce < 0; k++) begin
      if (isRd && nandDqOe) oeSeen = 1;
      if (tf < 0 && (isRd ? !nandReN : !nandWeN)) begin
        tf = cyc; cleAt = nandCle; aleAt = nandAle; oeAt = nandDqOe; dqAt = nandDqOut;
        otherLow = isRd ? !nandWeN : !nandReN;
      end
      if (tf >= 0 && tr < 0 && (isRd ? nandReN : nandWeN)) tr = cyc;
      if (rspValid) begin trsp = cyc; rsp = rspData; end
      if (nandCeN) tce = cyc;
      else @(negedge clk);
    end
    expTf = ((tc + eff(cS)) > (lastRise + g)) ? (tc + eff(cS)) : (lastRise + g);
    if (prevKind == K_RD && kind != K_RD)
      chk(tf == expTf, "R5 read-to-write spacing", 32'(tf - tc), 32'(expTf - tc));
    else if (prevKind == K_RD)
      chk(tf == expTf, "R5 read-to-read spacing", 32'(tf - tc), 32'(expTf - tc));
    else if (prevKind == K_ADDR && (kind == K_DWR || kind == K_RD))
      chk(tf == expTf, "R7 address-to-data spacing", 32'(tf - tc), 32'(expTf - tc));
    else if (kind == K_RD && prevKind != K_NONE)
      chk(tf == expTf, "R6 write-to-read spacing", 32'(tf - tc), 32'(expTf - tc));
    else
      chk(tf == expTf, "R3 setup before strobe", 32'(tf - tc), 32'(expTf - tc));
    chk(tr - tf == eff(cL), "R2 strobe low width", 32'(tr - tf), 32'(eff(cL)));
    chk(tce - tr == eff(cH), "R2 high time to cycle end", 32'(tce - tr), 32'(eff(cH)));
    chk(cleAt == (ty == 0) && aleAt == (ty == 1) && !otherLow, "R1 latch enables and strobe",
        {29'd0, otherLow, cleAt, aleAt}, {30'd0, ty == 0, ty == 1});
    if (isRd) begin
      chk(!oeSeen && !oeAt, "R12 bus released for read", 32'(oeSeen), 0);
      expRsp = tf + eff(cA);
      chk(trsp == expRsp, "R4 response timing", 32'(trsp - tf), 32'(eff(cA)));
      bv = busVal(tf + eff(cA) - 1);
      expData = wd ? {8'h00, bv[15:8], 8'h00, bv[7:0]} : {24'h0, bv[7:0]};
      chk(rsp == expData, wd ? "R9 wide read packing" : "R9 narrow read value", rsp, expData);
    end else begin
      expDq = (ty == 2 && wd) ? {d[23:16], d[7:0]} : {8'h00, d[7:0]};
      chk(oeAt, "R12 bus driven on write", 32'(oeAt), 1);
      if (ty == 2) chk(dqAt == expDq, "R8 write data lanes", 32'(dqAt), 32'(expDq));
      else         chk(dqAt == expDq, "R10 command/address 8-bit", 32'(dqAt), 32'(expDq));
    end
    lastRise = tr;
    prevKind = kind;
  endtask

  task automatic ignoredReq();
    bit anyBusy;
    @(negedge clk);
    reqValid = 1'b1; reqType = 2'd3; reqWrite = 1'b1; reqData = 32'hFF;
    @(negedge clk);
    reqValid = 1'b0;
    anyBusy = 0;
    for (int k = 0; k < 5; k++) begin
      if (busy || !nandCeN) anyBusy = 1;
      @(negedge clk);
    end
    chk(!anyBusy, "R13 type 3 ignored", 32'(anyBusy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && !nandDqOe && !busy && !rspValid,
        "R14 reset outputs", {26'd0, nandCeN, nandWeN, nandReN, nandCle, nandAle, nandDqOe},
        32'h38);
    rstN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cS  = CNT_W'(i % 3);
      cL  = CNT_W'(i % 4);
      cH  = CNT_W'((i + 1) % 3);
      cA  = (i == 0) ? '0 : CNT_W'(eff(CNT_W'(i % 4)) + (i % 2));
      cRW = CNT_W'((i * 3) % 7);
      cRR = CNT_W'((i * 5) % 9);
      cWR = CNT_W'((i * 2 + 3) % 11);
      cAD = CNT_W'((i * 7) % 13);
      // R11: configurations with zero counts behave as count 1
      runCycle(0, 1, 0, 32'h00000070 + 32'(i));
      runCycle(1, 1, 0, 32'h00000012 + 32'(i));
      runCycle(1, 1, 0, 32'h00000034 + 32'(i));
      runCycle(2, 0, 0, 32'h0);
      runCycle(2, 0, 0, 32'h0);
      runCycle(2, 1, 0, 32'hABCD00C3 + 32'(i));
      runCycle(2, 0, 0, 32'h0);
      runCycle(1, 1, 1, 32'h00FF0056);
      runCycle(2, 1, 1, 32'h005A0096 + 32'(i << 16));
      runCycle(1, 1, 0, 32'h00000021);
      runCycle(2, 0, 1, 32'h0);
      runCycle(0, 1, 1, 32'h00EE0090);
      ignoredReq();
    end
    finishRun();
  end

endmodule